// File: doc/BRIEF.md
# Cache Flush Sequencer

This block runs whole-cache flush operations for a processor core that keeps separate instruction and data caches. It takes requests from three places: an external flush input driven by system logic, a software command that copies back dirty data and then invalidates, and a software command that only invalidates. For the two copy-back kinds it walks every line of the data cache in index order and reads each line's state. For every line in the modified state it hands the line address to the bus interface and waits for that transfer to finish. After the walk it clears the valid bits of both caches at once. A flush started by the external input then ends with a flush-acknowledge special bus cycle.

The cache arrays, the bus protocol and the snoop logic sit outside the block. The block reaches them through plain ports. A line-index output selects the line whose modified flag and tag the cache returns in the same cycle. A request/done pair carries each writeback. Two one-cycle pulses clear the valid bits. A second request/done pair carries the acknowledge cycle. A busy output tells the rest of the core that no cache lookup may take place.

Top module: `flush_seq`

## Requirements
- R1: Out of reset, busy, wb_req, inv_icache, inv_dcache and fack_req are all low and line_idx is 0.
- R2: A request that is accepted on a clock edge makes busy high from that edge on. Busy stays high until the final step of the flush has completed and falls on the edge after that step.
- R3: For the external flush and the copy-back command, line indices 0 to SETS*WAYS-1 are visited in increasing order. The index encodes way*SETS+set, so the set is the low log2(SETS) bits. One writeback is issued for each line reported as modified, and none for any other line. The writebacks come in index order, with wb_addr = {line_tag, set, log2(LINE_BYTES) zero bits}.
- R4: Once wb_req is raised, it and wb_addr stay unchanged until wb_done is sampled high. line_idx does not advance before that.
- R5: Invalidation is a single-cycle pulse that is high on inv_icache and inv_dcache together. It is issued exactly once per flush, after the last writeback has completed, and never while wb_req is high.
- R6: The invalidate-only command issues no writeback even when lines are modified. Its invalidation pulse appears in the first busy cycle, so busy lasts one cycle.
- R7: Only a flush started by the external input raises fack_req. It rises in the cycle after the invalidation pulse and stays high until fack_done is sampled high.
- R8: Requests of any kind that arrive while busy is high are ignored. They start no second flush and change nothing in the flush under way.
- R9: When requests arrive together, the external input wins over the copy-back command, and the copy-back command wins over the invalidate-only command.
- R10: During the walk an unmodified line takes one cycle and a modified line takes one cycle plus the wb_req cycles. A copy-back flush is therefore busy for SETS*WAYS + (wb_req cycles) + 1 cycles, plus the fack_req cycles for an external flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_pin | input | 1 | External flush request, active high, sampled each edge |
| cmd_wbinv | input | 1 | Software copy-back-and-invalidate request pulse |
| cmd_inv | input | 1 | Software invalidate-only request pulse |
| line_idx | output | log2(SETS*WAYS) | Line being examined, encoded way*SETS+set |
| line_dirty | input | 1 | Modified flag of the line at line_idx, same cycle |
| line_tag | input | ADDR_W-log2(SETS)-log2(LINE_BYTES) | Tag of the line at line_idx, same cycle |
| wb_req | output | 1 | Writeback request to the bus interface |
| wb_addr | output | ADDR_W | Line-aligned address of the writeback |
| wb_done | input | 1 | One-cycle writeback completion pulse |
| inv_icache | output | 1 | Clear every instruction-cache valid bit |
| inv_dcache | output | 1 | Clear every data-cache valid bit |
| fack_req | output | 1 | Flush-acknowledge special cycle request |
| fack_done | input | 1 | One-cycle completion pulse of the acknowledge cycle |
| busy | output | 1 | Flush in progress, cache lookups forbidden |

## Verification
A request driven before an edge shows busy high at the next sample point. Each wb_req lasts exactly as many cycles as the bus model waits before pulsing wb_done. The invalidation pulse comes one cycle after the last line is left, and fack_req starts one cycle after that pulse. The bench drives inputs and samples outputs only on falling edges, so each edge has one cycle of latency. It checks every flush's busy length against the cycle formula of R10, built from the number of modified lines and the programmed response delays. It checks the cycle of the first fack_req against the cycle of the invalidation pulse. A response model counts any change of wb_addr or line_idx during an open writeback.

// File: rtl/flush_pkg.sv
// Shared types for the cache flush sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package flush_pkg;

    // Which request started the flush under way.
    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_PIN     = 2'd1,
        SRC_WBINV   = 2'd2,
        SRC_INVONLY = 2'd3
    } flush_src_e;

    // Sequencer phases.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SCAN  = 3'd1,
        ST_WB    = 3'd2,
        ST_INVAL = 3'd3,
        ST_FACK  = 3'd4
    } flush_state_e;

    // True when the source copies dirty lines back before invalidation.
    function automatic logic src_copies_back(flush_src_e s);
        return (s == SRC_PIN) || (s == SRC_WBINV);
    endfunction

    // True when the source ends with the acknowledge special cycle.
    function automatic logic src_needs_ack(flush_src_e s);
        return (s == SRC_PIN);
    endfunction

endpackage

// File: rtl/flush_arb.sv
// Request arbiter: picks one flush source per cycle by fixed priority
// (external pin, then copy-back command, then invalidate-only) and
// only while the sequencer is idle.
// Assumes requests that lose arbitration or arrive while busy are dropped.
module flush_arb
    import flush_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush_pin,
    input  logic       cmd_wbinv,
    input  logic       cmd_inv,
    input  logic       busy,
    output logic       accept,
    output flush_src_e src
);

    // Fixed-priority selection of the winning source.
    always_comb begin
        if (flush_pin)      src = SRC_PIN;
        else if (cmd_wbinv) src = SRC_WBINV;
        else if (cmd_inv)   src = SRC_INVONLY;
        else                src = SRC_NONE;
    end

    // Accept only a real request and only while idle.
    assign accept = (src != SRC_NONE) && !busy;

    // R9: a pin request that is accepted is always taken as a pin flush.
    a_r9_pin_first: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && flush_pin) |-> (src == SRC_PIN));

    // R9: the copy-back command beats invalidate-only.
    a_r9_wbinv_over_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !flush_pin && cmd_wbinv) |-> (src == SRC_WBINV));

endmodule

// File: rtl/flush_scan.sv
// Line index walker: holds the index of the line under examination,
// clears to 0 at the start of a flush and steps by one on request.
// Assumes LINES is a power of two so the index wraps cleanly.
module flush_scan #(
    parameter int LINES = 32,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    logic [IDX_W-1:0] idx_q;

    // Index register: reset, restart or single step.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (clear)   idx_q <= '0;
        else if (advance) idx_q <= idx_q + 1'b1;
    end

    assign idx     = idx_q;
    assign at_last = (idx_q == LAST_IDX);

    // R3: a step moves the index by exactly one line.
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |=> (idx == $past(idx) + 1'b1));

    // R3: the walk never steps past the last line.
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !at_last);

endmodule

// File: rtl/flush_wb_port.sv
// Writeback port: captures the line address when a writeback is
// launched and holds request and address until the bus reports done.
// Assumes done is a one-cycle pulse that comes only while the request is up.
module flush_wb_port #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              done,
    output logic              req,
    output logic [ADDR_W-1:0] addr
);

    logic              req_q;
    logic [ADDR_W-1:0] addr_q;

    // Request flag: set on launch, cleared by the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      req_q <= 1'b0;
        else if (launch) req_q <= 1'b1;
        else if (done)   req_q <= 1'b0;
    end

    // Address holding register, loaded only at launch.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (launch) addr_q <= addr_in;
    end

    assign req  = req_q;
    assign addr = addr_q;

    // R4: an open request keeps its address until completion.
    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !done) |=> (req && $stable(addr)));

    // R4: no new launch while a request is still open.
    a_r4_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !done) |-> !launch);

endmodule

// File: rtl/flush_ctrl.sv
// Flush phase controller: remembers the flush source, walks the lines
// (copy-back kinds only), issues writebacks for modified lines, pulses
// the invalidation and runs the acknowledge cycle for pin flushes.
// Assumes the cache returns the state of line idx in the same cycle.
module flush_ctrl
    import flush_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  flush_src_e src,
    input  logic       line_dirty,
    input  logic       at_last,
    input  logic       wb_done,
    input  logic       fack_done,
    output logic       scan_clear,
    output logic       scan_advance,
    output logic       wb_launch,
    output logic       inval,
    output logic       fack_req,
    output logic       busy
);

    flush_state_e state_q, state_d;
    flush_src_e   mode_q;

    // Next-phase and step decisions.
    always_comb begin
        state_d      = state_q;
        scan_clear   = 1'b0;
        scan_advance = 1'b0;
        wb_launch    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    scan_clear = 1'b1;
                    state_d    = src_copies_back(src) ? ST_SCAN : ST_INVAL;
                end
            end
            ST_SCAN: begin
                if (line_dirty) begin
                    wb_launch = 1'b1;
                    state_d   = ST_WB;
                end else if (at_last) begin
                    state_d = ST_INVAL;
                end else begin
                    scan_advance = 1'b1;
                end
            end
            ST_WB: begin
                if (wb_done) begin
                    if (at_last) begin
                        state_d = ST_INVAL;
                    end else begin
                        scan_advance = 1'b1;
                        state_d      = ST_SCAN;
                    end
                end
            end
            ST_INVAL: begin
                state_d = src_needs_ack(mode_q) ? ST_FACK : ST_IDLE;
            end
            ST_FACK: begin
                if (fack_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Source register, loaded only when a flush is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mode_q <= SRC_NONE;
        else if (accept && state_q == ST_IDLE) mode_q <= src;
    end

    assign inval    = (state_q == ST_INVAL);
    assign fack_req = (state_q == ST_FACK);
    assign busy     = (state_q != ST_IDLE);

    // R2: an accepted request makes busy high on the next cycle.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !busy) |=> busy);

    // R5: the invalidation pulse lasts one cycle.
    a_r5_inval_single: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !inval);

    // R6: an invalidate-only flush never launches a writeback.
    a_r6_no_wb_for_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == SRC_INVONLY) |-> !wb_launch);

    // R7: the acknowledge cycle belongs to pin flushes only.
    a_r7_ack_pin_only: assert property (@(posedge clk) disable iff (!rst_n)
        fack_req |-> (mode_q == SRC_PIN));

    // R7: the acknowledge cycle starts right after the invalidation pulse.
    a_r7_ack_follows_inval: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fack_req) |-> $past(inval));

    // R8: the source of a running flush cannot be replaced.
    a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_d != ST_IDLE) |=> $stable(mode_q));

endmodule

// File: rtl/flush_seq.sv
// Cache flush sequencer top: joins the arbiter, the line walker, the
// writeback port and the phase controller, and forms the writeback
// address from the returned tag and the set part of the line index.
// Assumes SETS, WAYS and LINE_BYTES are powers of two and that the
// line index encodes way*SETS+set.
module flush_seq #(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 16,
    parameter int WAYS       = 2,
    parameter int LINE_BYTES = 32,
    localparam int LINES     = SETS * WAYS,
    localparam int IDX_W     = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int SET_W     = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int TAG_W     = ADDR_W - SET_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_pin,
    input  logic              cmd_wbinv,
    input  logic              cmd_inv,
    output logic [IDX_W-1:0]  line_idx,
    input  logic              line_dirty,
    input  logic [TAG_W-1:0]  line_tag,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_done,
    output logic              inv_icache,
    output logic              inv_dcache,
    output logic              fack_req,
    input  logic              fack_done,
    output logic              busy
);
    import flush_pkg::*;

    logic              accept;
    flush_src_e        src;
    logic              scan_clear;
    logic              scan_advance;
    logic              at_last;
    logic              wb_launch;
    logic              inval;
    logic [ADDR_W-1:0] line_addr;
    logic [SET_W-1:0]  set_part;

    flush_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_pin (flush_pin),
        .cmd_wbinv (cmd_wbinv),
        .cmd_inv   (cmd_inv),
        .busy      (busy),
        .accept    (accept),
        .src       (src)
    );

    flush_scan #(
        .LINES (LINES)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (scan_clear),
        .advance (scan_advance),
        .idx     (line_idx),
        .at_last (at_last)
    );

    // Set part of the index: the low bits, or a single zero set.
    generate
        if (SETS > 1) begin : g_multi_set
            assign set_part = line_idx[SET_W-1:0];
        end else begin : g_one_set
            assign set_part = '0;
        end
    endgenerate

    // Line-aligned address of the line under examination.
    assign line_addr = {line_tag, set_part, {OFF_W{1'b0}}};

    flush_wb_port #(
        .ADDR_W (ADDR_W)
    ) u_wb (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (wb_launch),
        .addr_in (line_addr),
        .done    (wb_done),
        .req     (wb_req),
        .addr    (wb_addr)
    );

    flush_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .src          (src),
        .line_dirty   (line_dirty),
        .at_last      (at_last),
        .wb_done      (wb_done),
        .fack_done    (fack_done),
        .scan_clear   (scan_clear),
        .scan_advance (scan_advance),
        .wb_launch    (wb_launch),
        .inval        (inval),
        .fack_req     (fack_req),
        .busy         (busy)
    );

    assign inv_icache = inval;
    assign inv_dcache = inval;

    // R5: invalidation never overlaps an open writeback.
    a_r5_inval_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        inv_dcache |-> !wb_req);

    // R4: the walk holds its line while a writeback is open.
    a_r4_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_done) |=> $stable(line_idx));

    // R2: outside a flush no cache-side action is requested.
    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wb_req && !inv_icache && !fack_req));

endmodule

// File: tb/flush_seq_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the cache flush sequencer: a cache model returns
// modified flags and tags, bus models answer writebacks and the
// acknowledge cycle after programmable delays, one task per scenario.
module flush_seq_tb_top;

    localparam int ADDR_W = 32;
    localparam int SETS   = 16;
    localparam int WAYS   = 2;
    localparam int LB     = 32;
    localparam int LINES  = SETS * WAYS;
    localparam int IDX_W  = $clog2(LINES);
    localparam int SET_W  = $clog2(SETS);
    localparam int OFF_W  = $clog2(LB);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_pin = 1'b0, cmd_wbinv = 1'b0, cmd_inv = 1'b0;
    logic [IDX_W-1:0] line_idx;
    logic line_dirty;
    logic [TAG_W-1:0] line_tag;
    logic wb_req;
    logic [ADDR_W-1:0] wb_addr;
    logic wb_done = 1'b0;
    logic inv_icache, inv_dcache, fack_req;
    logic fack_done = 1'b0;
    logic busy;

    always #2.5 clk = ~clk;

    flush_seq dut_i (
        .clk(clk), .rst_n(rst_n), .flush_pin(flush_pin), .cmd_wbinv(cmd_wbinv),
        .cmd_inv(cmd_inv), .line_idx(line_idx), .line_dirty(line_dirty),
        .line_tag(line_tag), .wb_req(wb_req), .wb_addr(wb_addr), .wb_done(wb_done),
        .inv_icache(inv_icache), .inv_dcache(inv_dcache), .fack_req(fack_req),
        .fack_done(fack_done), .busy(busy)
    );

    int checks = 0;
    int failures = 0;

    // Cache model.
    logic [LINES-1:0] dirty_map = '0;
    function automatic logic [TAG_W-1:0] tag_of(int idx);
        return TAG_W'(idx * 40503 + 1234);
    endfunction
    assign line_dirty = dirty_map[line_idx];
    always_comb line_tag = tag_of(int'(line_idx));

    // Bus models and event log.
    int wb_delay = 1;
    int fack_delay = 1;
    int cyc = 0;
    int wb_cnt = 0, wb_seen = 0, wb_unstable = 0;
    logic [ADDR_W-1:0] wb_open_addr = '0;
    logic [IDX_W-1:0] wb_open_idx = '0;
    logic [ADDR_W-1:0] wb_log [0:LINES-1];
    int inv_seen = 0, inv_split = 0, inv_wb_at = 0, inv_cyc = 0;
    int f_cnt = 0, fack_seen = 0, fack_first = -1;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (wb_done) begin
            wb_done = 1'b0;
        end else if (wb_req) begin
            if (wb_cnt == 0) begin
                wb_open_addr = wb_addr;
                wb_open_idx  = line_idx;
            end else if (wb_addr != wb_open_addr || line_idx != wb_open_idx) begin
                wb_unstable = wb_unstable + 1;
            end
            wb_cnt = wb_cnt + 1;
            if (wb_cnt == wb_delay) begin
                if (wb_seen < LINES) wb_log[wb_seen] = wb_addr;
                wb_seen = wb_seen + 1;
                wb_done = 1'b1;
                wb_cnt  = 0;
            end
        end
        if (inv_icache != inv_dcache) inv_split = inv_split + 1;
        if (inv_icache) begin
            inv_seen  = inv_seen + 1;
            inv_wb_at = wb_seen;
            inv_cyc   = cyc;
        end
        if (fack_done) begin
            fack_done = 1'b0;
        end else if (fack_req) begin
            if (f_cnt == 0 && fack_first < 0) fack_first = cyc;
            f_cnt = f_cnt + 1;
            if (f_cnt == fack_delay) begin
                fack_seen = fack_seen + 1;
                fack_done = 1'b1;
                f_cnt     = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        wb_seen = 0; wb_unstable = 0; inv_seen = 0; inv_split = 0;
        inv_wb_at = 0; fack_seen = 0; fack_first = -1; inv_cyc = 0;
    endtask

    // Fire one set of requests, optionally inject more while busy, and
    // return the number of falling edges with busy high.
    task automatic fire(input bit p, input bit w, input bit i, input bit inject,
                        output int busy_cycles);
        int guard;
        @(negedge clk);
        flush_pin = p; cmd_wbinv = w; cmd_inv = i;
        @(negedge clk);
        flush_pin = 1'b0; cmd_wbinv = 1'b0; cmd_inv = 1'b0;
        busy_cycles = 0;
        guard = 0;
        while (busy && guard < 5000) begin
            busy_cycles = busy_cycles + 1;
            guard = guard + 1;
            if (inject && busy_cycles == 3) begin
                flush_pin = 1'b1; cmd_wbinv = 1'b1; cmd_inv = 1'b1;
            end else begin
                flush_pin = 1'b0; cmd_wbinv = 1'b0; cmd_inv = 1'b0;
            end
            @(negedge clk);
        end
        flush_pin = 1'b0; cmd_wbinv = 1'b0; cmd_inv = 1'b0;
        @(negedge clk);
        #1;
    endtask

    function automatic int count_dirty();
        int n = 0;
        for (int k = 0; k < LINES; k++) if (dirty_map[k]) n++;
        return n;
    endfunction

    // Compare the writeback log with the modified lines in index order.
    task automatic check_wb_list(input string req);
        int pos = 0;
        check(wb_seen == count_dirty(), req, "writeback count", wb_seen, count_dirty());
        for (int k = 0; k < LINES; k++) begin
            if (dirty_map[k] && pos < wb_seen) begin
                logic [ADDR_W-1:0] exp_a;
                exp_a = {tag_of(k), SET_W'(k % SETS), {OFF_W{1'b0}}};
                check(wb_log[pos] == exp_a, req, "writeback address", wb_log[pos], exp_a);
                pos++;
            end
        end
    endtask

    // Copy-back flush (pin or command) with full result checks.
    task automatic t_copyback(input bit pin, input logic [LINES-1:0] map,
                              input int wd, input int fd, input string name);
        int bc, nd, exp_bc;
        dirty_map = map; wb_delay = wd; fack_delay = fd;
        clear_logs();
        fire(pin, !pin, 1'b0, 1'b0, bc);
        nd = count_dirty();
        exp_bc = LINES + nd * wd + 1 + (pin ? fd : 0);
        $display("scenario %s", name);
        check(bc == exp_bc, "R10", "busy cycles", bc, exp_bc);
        check_wb_list("R3");
        check(wb_unstable == 0, "R4", "unstable writeback", wb_unstable, 0);
        check(inv_seen == 1, "R5", "invalidation count", inv_seen, 1);
        check(inv_split == 0, "R5", "icache/dcache pulse mismatch", inv_split, 0);
        check(inv_wb_at == nd, "R5", "writebacks before invalidation", inv_wb_at, nd);
        check(fack_seen == (pin ? 1 : 0), "R7", "acknowledge cycles", fack_seen, pin ? 1 : 0);
        if (pin)
            check(fack_first == inv_cyc + 1, "R7", "acknowledge start cycle", fack_first, inv_cyc + 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 0 && wb_req == 0 && fack_req == 0, "R1", "busy/wb_req/fack_req",
              {busy, wb_req, fack_req}, 0);
        check(inv_icache == 0 && inv_dcache == 0, "R1", "invalidate outputs",
              {inv_icache, inv_dcache}, 0);
        check(line_idx == 0, "R1", "line_idx", line_idx, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_busy_rise();
        dirty_map = '0;
        @(negedge clk);
        cmd_inv = 1'b1;
        check(busy == 0, "R2", "busy before edge", busy, 0);
        @(negedge clk);
        cmd_inv = 1'b0;
        check(busy == 1, "R2", "busy one edge after request", busy, 1);
        @(negedge clk);
        check(busy == 0, "R2", "busy after final step", busy, 0);
        @(negedge clk);
    endtask

    task automatic t_invonly();
        int bc;
        dirty_map = {LINES{1'b1}};
        clear_logs();
        fire(1'b0, 1'b0, 1'b1, 1'b0, bc);
        check(bc == 1, "R6", "busy cycles", bc, 1);
        check(wb_seen == 0, "R6", "writebacks", wb_seen, 0);
        check(inv_seen == 1, "R6", "invalidation count", inv_seen, 1);
        check(fack_seen == 0, "R7", "acknowledge cycles", fack_seen, 0);
    endtask

    task automatic t_priority();
        int bc;
        dirty_map = '0; dirty_map[5] = 1'b1; wb_delay = 1; fack_delay = 1;
        clear_logs();
        fire(1'b1, 1'b1, 1'b1, 1'b0, bc);
        check(fack_seen == 1, "R9", "pin wins: acknowledge", fack_seen, 1);
        check(wb_seen == 1, "R9", "pin wins: writebacks", wb_seen, 1);
        clear_logs();
        fire(1'b0, 1'b1, 1'b1, 1'b0, bc);
        check(wb_seen == 1, "R9", "copy-back wins: writebacks", wb_seen, 1);
        check(fack_seen == 0, "R9", "copy-back wins: acknowledge", fack_seen, 0);
        check(bc == LINES + 2, "R9", "copy-back wins: busy cycles", bc, LINES + 2);
    endtask

    task automatic t_ignore_busy();
        int bc;
        dirty_map = '0; dirty_map[0] = 1'b1; dirty_map[LINES-1] = 1'b1;
        wb_delay = 2; fack_delay = 2;
        clear_logs();
        fire(1'b0, 1'b1, 1'b0, 1'b1, bc);
        check(bc == LINES + 2 * 2 + 1, "R8", "busy cycles with requests injected",
              bc, LINES + 5);
        check(fack_seen == 0, "R8", "no acknowledge from ignored pin", fack_seen, 0);
        repeat (4) @(negedge clk);
        check(busy == 0, "R8", "no second flush", busy, 0);
        check(inv_seen == 1, "R8", "invalidation count", inv_seen, 1);
        check(wb_seen == 2, "R8", "writeback count", wb_seen, 2);
    endtask

    logic done_flag = 1'b0;

    initial begin
        #(5.0 * 150000);
        if (!done_flag) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [LINES-1:0] m;
        t_reset();
        t_busy_rise();
        t_copyback(1'b1, '0, 1, 1, "pin, all clean");
        t_copyback(1'b1, {LINES{1'b1}}, 1, 3, "pin, all dirty");
        m = '0; m[0] = 1'b1; m[LINES-1] = 1'b1; m[SETS] = 1'b1;
        t_copyback(1'b1, m, 4, 2, "pin, first/last/way1");
        m = '0;
        for (int k = 0; k < LINES; k += 3) m[k] = 1'b1;
        t_copyback(1'b0, m, 2, 1, "copy-back command, sparse");
        t_invonly();
        t_priority();
        t_ignore_busy();
        done_flag = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule